// File: doc/BRIEF.md
# Temperature Sensor Register Front End

This block is the byte-level register layer of a two-wire temperature sensor. A bit engine in front of it decodes the serial line and hands it one event per clock: a start condition, a stop condition, a received byte, or a request for the next byte to send. The block keeps a register pointer and a byte-phase counter. It serves four registers: a live temperature reading taken from an input port, an 8-bit configuration byte, and two 16-bit thresholds (hysteresis and overtemperature).

After a start condition, the first byte the host writes loads the pointer. Each later access moves one byte of the selected register. For the 16-bit registers the high byte goes first and the low byte follows. The phase counter saturates, so any further accesses in the same transfer keep hitting the low byte. A read that follows a repeated start reuses the pointer already held. This gives the usual "write pointer, repeated start, read two bytes" sequence.

Read data is combinational: the byte appears on the output in the same cycle as the request.

Top module: `tsens_regs`

## Requirements
- R1: After reset the pointer is 0, the byte phase is at its beginning, configuration is 0x00, hysteresis is 0x4B00 and overtemperature is 0x5000.
- R2: The first byte written after a start or stop condition is stored as the 8-bit pointer and changes no register.
- R3: Only pointer bits [1:0] select the register: 0 temperature, 1 configuration, 2 hysteresis, 3 overtemperature. Bits [7:2] are ignored.
- R4: For temperature and both thresholds, the first data access after the pointer (or after a start when no pointer byte is written) moves bits [15:8], and the next access moves bits [7:0].
- R5: The byte phase saturates: every data access after the second one in a transfer moves bits [7:0] again.
- R6: Configuration is one byte. Reads return it in every phase, and a data write in any phase replaces it.
- R7: Temperature is read-only. Data writes to it are accepted and discarded.
- R8: A start condition returns the phase to its beginning and keeps the pointer. A following read therefore returns the high byte of the register the held pointer selects.
- R9: A stop condition also returns the phase to its beginning and keeps the pointer.
- R10: `o_rd_data` is valid in the same cycle as `i_rd_req` and follows the live value of `i_temp`.
- R11: A threshold write in the high phase replaces bits [15:8]. Each later write in the same transfer replaces bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | Start or repeated-start event |
| i_stop | input | 1 | Stop event |
| i_wr_valid | input | 1 | A byte was received from the host |
| i_wr_data | input | 8 | Received byte |
| i_rd_req | input | 1 | The host takes one byte this cycle |
| o_rd_data | output | 8 | Byte to send, combinational |
| i_temp | input | 16 | Current temperature code |

## Verification
The hardest state to reach is the one where the phase counter is already saturated and a new event arrives. Two cases matter: a start or stop must bring the next read back to the high byte, and a stop must turn the next write back into a pointer load instead of a low-byte write. The stimulus builds transfers that end in the saturated phase with reads, with writes, or with a mix of both. It then issues a repeated start, or a stop with no start, and reads or writes straight away. A behavioural model tracks the pointer, the phase and the register contents and predicts every output byte. The same approach applies when the upper pointer bits are non-zero and when the temperature input changes between transfers.

// File: rtl/tsens_pkg.sv
package tsens_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEL_TEMP = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_HYST = 2'd2,
        SEL_TOS  = 2'd3
    } sel_e;

    localparam int unsigned SEL_W   = 2;
    localparam int unsigned N_THR   = 2;

endpackage

// File: rtl/tsens_seq.sv
module tsens_seq
    import tsens_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [PTR_W-1:0]  ptr_q,
    output phase_e            phase_q,
    output logic              data_wr,
    output logic              hi_sel
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        phase_e           phase;
    } seq_st_t;

    seq_st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        data_wr = 1'b0;
        if (start || stop) begin
            st_d.phase = PH_IDLE;
        end else if (wr_valid) begin
            if (st_q.phase == PH_IDLE) begin
                st_d.ptr   = wr_data[PTR_W-1:0];
                st_d.phase = PH_HIGH;
            end else begin
                data_wr    = 1'b1;
                st_d.phase = PH_LOW;
            end
        end else if (rd_req) begin
            st_d.phase = PH_LOW;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr   <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_q   = st_q.ptr;
    assign phase_q = st_q.phase;
    assign hi_sel  = (st_q.phase != PH_LOW);

endmodule

// File: rtl/tsens_store.sv
module tsens_store
    import tsens_pkg::*;
#(
    parameter int unsigned        DATA_W   = 8,
    parameter logic [DATA_W-1:0]  CFG_RST  = '0,
    parameter logic [2*DATA_W-1:0] HYST_RST = 16'h4B00,
    parameter logic [2*DATA_W-1:0] TOS_RST  = 16'h5000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  sel_e                               sel,
    input  logic                               hi_sel,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [DATA_W-1:0]                  cfg_q,
    output logic [N_THR-1:0][2*DATA_W-1:0]     thr_q
);

    localparam int unsigned WIDE_W = 2 * DATA_W;

    logic [DATA_W-1:0] cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && sel == SEL_CFG) cfg_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    for (genvar k = 0; k < N_THR; k++) begin : g_thr
        localparam logic [WIDE_W-1:0] RST_V  = (k == 0) ? HYST_RST : TOS_RST;
        localparam logic [SEL_W-1:0]  MY_SEL = (k == 0) ? SEL_HYST : SEL_TOS;

        logic [WIDE_W-1:0] thr_d;

        always_comb begin
            thr_d = thr_q[k];
            if (wr_en && sel == sel_e'(MY_SEL)) begin
                if (hi_sel) thr_d[WIDE_W-1:DATA_W] = wr_data;
                else        thr_d[DATA_W-1:0]      = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) thr_q[k] <= RST_V;
            else        thr_q[k] <= thr_d;
        end
    end

endmodule

// File: rtl/tsens_rdmux.sv
module tsens_rdmux
    import tsens_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  sel_e                           sel,
    input  logic                           hi_sel,
    input  logic [2*DATA_W-1:0]            temp,
    input  logic [DATA_W-1:0]              cfg,
    input  logic [N_THR-1:0][2*DATA_W-1:0] thr,
    output logic [DATA_W-1:0]              rd_data
);

    logic [2*DATA_W-1:0] wide;

    always_comb begin
        case (sel)
            SEL_HYST: wide = thr[0];
            SEL_TOS:  wide = thr[1];
            default:  wide = temp;
        endcase
        if (sel == SEL_CFG)  rd_data = cfg;
        else if (hi_sel)     rd_data = wide[2*DATA_W-1:DATA_W];
        else                 rd_data = wide[DATA_W-1:0];
    end

endmodule

// File: rtl/tsens_regs.sv
module tsens_regs
    import tsens_pkg::*;
#(
    parameter int unsigned         DATA_W   = 8,
    parameter int unsigned         PTR_W    = 8,
    parameter logic [DATA_W-1:0]   CFG_RST  = '0,
    parameter logic [2*DATA_W-1:0] HYST_RST = 16'h4B00,
    parameter logic [2*DATA_W-1:0] TOS_RST  = 16'h5000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_start,
    input  logic                i_stop,
    input  logic                i_wr_valid,
    input  logic [DATA_W-1:0]   i_wr_data,
    input  logic                i_rd_req,
    output logic [DATA_W-1:0]   o_rd_data,
    input  logic [2*DATA_W-1:0] i_temp
);

    logic [PTR_W-1:0]                  ptr_q;
    phase_e                            phase_q;
    logic                              data_wr;
    logic                              hi_sel;
    sel_e                              sel;
    logic [DATA_W-1:0]                 cfg_q;
    logic [N_THR-1:0][2*DATA_W-1:0]    thr_q;

    tsens_seq #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (i_start),
        .stop     (i_stop),
        .wr_valid (i_wr_valid),
        .wr_data  (i_wr_data),
        .rd_req   (i_rd_req),
        .ptr_q    (ptr_q),
        .phase_q  (phase_q),
        .data_wr  (data_wr),
        .hi_sel   (hi_sel)
    );

    assign sel = sel_e'(ptr_q[SEL_W-1:0]);

    tsens_store #(
        .DATA_W   (DATA_W),
        .CFG_RST  (CFG_RST),
        .HYST_RST (HYST_RST),
        .TOS_RST  (TOS_RST)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_wr),
        .sel     (sel),
        .hi_sel  (hi_sel),
        .wr_data (i_wr_data),
        .cfg_q   (cfg_q),
        .thr_q   (thr_q)
    );

    tsens_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .sel     (sel),
        .hi_sel  (hi_sel),
        .temp    (i_temp),
        .cfg     (cfg_q),
        .thr     (thr_q),
        .rd_data (o_rd_data)
    );

endmodule

// File: rtl/tsens_regs_chk.sv
module tsens_regs_chk
    import tsens_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PTR_W  = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           i_start,
    input logic                           i_stop,
    input logic                           i_wr_valid,
    input logic                           i_rd_req,
    input logic [2*DATA_W-1:0]            i_temp,
    input logic [DATA_W-1:0]              o_rd_data,
    input logic [PTR_W-1:0]               ptr_q,
    input phase_e                         phase_q,
    input logic                           data_wr,
    input logic [DATA_W-1:0]              cfg_q,
    input logic [N_THR-1:0][2*DATA_W-1:0] thr_q
);

    // R5: the phase never takes the unused encoding
    p_phase_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != phase_e'(2'd3));

    // R5: once in the low phase, only start or stop leaves it
    p_phase_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LOW && !i_start && !i_stop) |=> phase_q == PH_LOW);

    // R8: start returns the phase to its beginning
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        i_start |=> phase_q == PH_IDLE);

    // R9: stop returns the phase to its beginning
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        i_stop |=> phase_q == PH_IDLE);

    // R2: the pointer moves only on a write in the first phase
    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_wr_valid && phase_q == PH_IDLE) |=> $stable(ptr_q));

    // R6 / R11: storage changes only on a data write
    p_store_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> ($stable(cfg_q) && $stable(thr_q)));

    // R6: configuration reads return the stored byte in any phase
    p_cfg_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[1:0] == 2'd1 |-> o_rd_data == cfg_q);

    // R10: temperature low byte is taken live from the input
    p_temp_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (i_rd_req && ptr_q[1:0] == 2'd0 && phase_q == PH_LOW)
        |-> o_rd_data == i_temp[DATA_W-1:0]);

endmodule

bind tsens_regs tsens_regs_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .i_start    (i_start),
    .i_stop     (i_stop),
    .i_wr_valid (i_wr_valid),
    .i_rd_req   (i_rd_req),
    .i_temp     (i_temp),
    .o_rd_data  (o_rd_data),
    .ptr_q      (ptr_q),
    .phase_q    (phase_q),
    .data_wr    (data_wr),
    .cfg_q      (cfg_q),
    .thr_q      (thr_q)
);

// File: tb/tsens_regs_bench.sv
module tsens_regs_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_start = 1'b0;
    logic        i_stop = 1'b0;
    logic        i_wr_valid = 1'b0;
    logic [7:0]  i_wr_data = 8'h00;
    logic        i_rd_req = 1'b0;
    logic [7:0]  o_rd_data;
    logic [15:0] i_temp = 16'h1234;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_ptr;
    int m_phase;   // 0 begin, 1 after pointer, 2 low byte
    int m_cfg;
    int m_hyst;
    int m_tos;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsens_regs u_tsens_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_start    (i_start),
        .i_stop     (i_stop),
        .i_wr_valid (i_wr_valid),
        .i_wr_data  (i_wr_data),
        .i_rd_req   (i_rd_req),
        .o_rd_data  (o_rd_data),
        .i_temp     (i_temp)
    );

    function automatic int model_byte();
        int wide;
        bit hi;
        hi = (m_phase != 2);
        case (m_ptr % 4)
            0: wide = int'(i_temp);
            1: return m_cfg;
            2: wide = m_hyst;
            default: wide = m_tos;
        endcase
        return hi ? ((wide >> 8) & 255) : (wide & 255);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // one clock: drive at the falling edge, compare, let the rising edge act
    task automatic step(input string tag, input bit st, input bit sp,
                        input bit wv, input int wd, input bit rr);
        @(negedge clk);
        i_start    = st;
        i_stop     = sp;
        i_wr_valid = wv;
        i_wr_data  = 8'(wd);
        i_rd_req   = rr;
        #1;
        check(tag, int'(o_rd_data), model_byte());
        @(posedge clk);
        #1;
        if (st || sp) begin
            m_phase = 0;
        end else if (wv) begin
            if (m_phase == 0) begin
                m_ptr = wd & 255;
                m_phase = 1;
            end else begin
                case (m_ptr % 4)
                    1: m_cfg = wd & 255;
                    2: m_hyst = (m_phase == 1) ? ((m_hyst & 255) | ((wd & 255) << 8))
                                               : ((m_hyst & 65280) | (wd & 255));
                    3: m_tos  = (m_phase == 1) ? ((m_tos & 255) | ((wd & 255) << 8))
                                               : ((m_tos & 65280) | (wd & 255));
                    default: ;
                endcase
                m_phase = 2;
            end
        end else if (rr) begin
            m_phase = 2;
        end
        i_start = 0; i_stop = 0; i_wr_valid = 0; i_rd_req = 0;
    endtask

    task automatic t_start(input string tag); step(tag, 1, 0, 0, 0, 0); endtask
    task automatic t_stop (input string tag); step(tag, 0, 1, 0, 0, 0); endtask
    task automatic t_wr(input string tag, input int d); step(tag, 0, 0, 1, d, 0); endtask
    task automatic t_rd(input string tag); step(tag, 0, 0, 0, 0, 1); endtask
    task automatic t_idle(input string tag); step(tag, 0, 0, 0, 0, 0); endtask

    // explicit expected-value read, independent of the model
    task automatic t_rd_exp(input string tag, input int exp);
        @(negedge clk);
        #1;
        check(tag, int'(o_rd_data), exp);
        t_rd(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_ptr = 0; m_phase = 0; m_cfg = 0; m_hyst = 16'h4B00; m_tos = 16'h5000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state, pointer 0 high byte
        t_idle("R1");
        t_start("R1"); t_wr("R2", 8'h02);
        t_rd_exp("R1", 8'h4B); t_rd_exp("R4", 8'h00); t_rd_exp("R5", 8'h00);
        t_start("R1"); t_wr("R2", 8'h03); t_rd_exp("R1", 8'h50); t_rd_exp("R4", 8'h00);
        t_start("R1"); t_wr("R2", 8'h01); t_rd_exp("R1", 8'h00);

        // R11: threshold write high then low, extra writes hit low byte
        t_start("R11"); t_wr("R11", 8'h02); t_wr("R11", 8'hA5); t_wr("R11", 8'h3C);
        t_wr("R11", 8'h7E); t_stop("R9");
        // R8: repeated start keeps pointer and restarts at the high byte
        t_start("R8"); t_rd_exp("R8", 8'hA5); t_rd_exp("R11", 8'h7E); t_rd_exp("R5", 8'h7E);

        // R6: configuration one byte in every phase
        t_start("R6"); t_wr("R6", 8'h01); t_wr("R6", 8'h5A);
        t_rd_exp("R6", 8'h5A); t_rd_exp("R6", 8'h5A);
        t_start("R6"); t_rd_exp("R6", 8'h5A); t_wr("R6", 8'hC3); t_rd_exp("R6", 8'hC3);

        // R7: temperature ignores writes
        t_start("R7"); t_wr("R7", 8'h00); t_wr("R7", 8'hFF); t_wr("R7", 8'hEE);
        t_rd_exp("R7", 8'h34);
        t_start("R7"); t_rd_exp("R7", 8'h12); t_rd_exp("R7", 8'h34);

        // R3: upper pointer bits ignored
        t_start("R3"); t_wr("R3", 8'hF7); t_rd_exp("R3", 8'h50); t_rd_exp("R3", 8'h00);
        t_start("R3"); t_wr("R3", 8'hFA); t_rd_exp("R3", 8'hA5);

        // R10: live temperature
        t_start("R10"); t_wr("R10", 8'h04);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); i_temp = 16'(16'h0F31 * (k + 3));
            t_start("R10"); t_rd("R10"); t_rd("R10"); t_rd("R10");
        end

        // R9: stop after saturated phase turns the next write into a pointer
        t_start("R9"); t_wr("R9", 8'h02); t_rd("R9"); t_wr("R9", 8'h11);
        t_stop("R9"); t_wr("R9", 8'h03); t_rd_exp("R9", 8'h50);
        t_stop("R9"); t_rd_exp("R9", 8'h50);

        // R4 / R5 mixed sequences across all registers
        for (int r = 0; r < 4; r++) begin
            t_start("R4"); t_wr("R4", 8'h08 + r);
            t_wr("R5", 8'h40 + r); t_rd("R5"); t_wr("R5", 8'h90 + r); t_rd("R5");
            t_start("R4"); t_rd("R4"); t_rd("R4"); t_rd("R5");
        end
        t_idle("R1");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule